// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the memory-mapped front end of a platform interrupt controller. A 32-bit request/response bus (valid, write flag, address, write data) reaches four address windows: one priority word per interrupt source, read-only pending words, a block of enable words for each context, and a block for each context that holds a threshold and a claim/complete register. The block keeps the priorities, enables and thresholds and drives them flat to the arbiter. It reads pending bits and the arbiter's chosen ID for each context from its inputs.

Every request is answered in the next cycle by a registered response. A read of a context's claim register returns the arbiter's current pick for that context and raises a one-cycle claim strobe. A write to the same register raises a one-cycle complete strobe that carries the written ID. Window bases and the two block strides are parameters, and the strides must be powers of two. Source ID 0 is reserved and never exists. Accesses that are malformed or that land outside a valid register are dropped. A read of one returns zero and raises the error flag of the response.

Top module: `intc_reg_decoder`

## Requirements
- R1: Every request cycle with `req_valid` high gives exactly one `rsp_valid` pulse in the next cycle, and in no other cycle. A write response always carries read data 0.
- R2: An address whose bits [1:0] are not 00 is rejected. A read returns 0, a write changes nothing, and `rsp_err` is 1.
- R3: Priority window: the word at byte offset 4·n belongs to source n+1, for n from 0 to NSRC-1. A write keeps the low PRIO_W bits of the data and drives `prio_o[(id-1)*PRIO_W +: PRIO_W]`. A read returns that value zero-extended.
- R4: Pending window: bit b of word w reports source 32·w+b, taken from `pend_i[s-1]` for source s. Bit 0 of word 0 and bits above NSRC read 0. A write is dropped with `rsp_err`.
- R5: Enable window: context = offset / EN_STRIDE, word = (offset mod EN_STRIDE) / 4. Bit b enables source 32·w+b and drives `en_o[ctx*NSRC + s-1]`. Bits for source 0 and above NSRC are ignored and read 0. A word index at or above ceil(NSRC/32) gives `rsp_err`, read 0 and no write.
- R6: Byte offset 0 of a context block is that context's threshold. A write with data at most MAX_PRIO is stored and drives `thr_o[ctx*PRIO_W +: PRIO_W]`. A larger value is dropped without error.
- R7: A read at byte offset 4 of a context block returns that context's slice of `claim_id_i`. In the response cycle it raises `claim_o` for one cycle, with `evt_ctx_o` set to the context.
- R8: A write at byte offset 4 with data from 1 to NSRC raises `complete_o` for one cycle in the response cycle, with `evt_ctx_o` and `complete_id_o` equal to the context and the data. Data 0 or above NSRC raises no strobe and sets `rsp_err`.
- R9: Any other offset in a context block, or any address outside the four windows, reads 0, drops a write and sets `rsp_err`.
- R10: While reset is active, all priorities, enables and thresholds are 0, and `rsp_valid`, `rsp_err`, `claim_o` and `complete_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Request was rejected or dropped |
| pend_i | input | NSRC | Pending flags, bit s-1 = source s |
| claim_id_i | input | NCTX*IDW | Arbiter's best ID for each context |
| prio_o | output | NSRC*PRIO_W | Source priorities |
| en_o | output | NCTX*NSRC | Enable bits for each context |
| thr_o | output | NCTX*PRIO_W | Threshold for each context |
| claim_o | output | 1 | Claim strobe |
| complete_o | output | 1 | Complete strobe |
| evt_ctx_o | output | CTXW | Context of the current strobe |
| complete_id_o | output | IDW | ID carried by the complete strobe |

## Verification
A complete write and a claim read can arrive in back-to-back cycles. Each strobe then has to leave the register stage while the other access is being decoded. The bench issues a complete to context 1 and, with no idle cycle between, a claim from context 0. The scoreboard then checks that each response cycle carries exactly the strobe, context and ID of its own request, and that the strobes never merge. The bench also checks that a claim strobe always comes in the same cycle as its registered read data.

// File: rtl/irqdec_pkg.sv
package irqdec_pkg;
  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_PRIO,
    ACC_PEND,
    ACC_EN,
    ACC_THR,
    ACC_CLAIM
  } acc_kind_e;
endpackage

// File: rtl/irqdec_addr_map.sv
module irqdec_addr_map
  import irqdec_pkg::*;
#(
  parameter int          NSRC       = 40,
  parameter int          NCTX       = 2,
  parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
  parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
  parameter logic [31:0] EN_BASE    = 32'h0000_2000,
  parameter logic [31:0] EN_STRIDE  = 32'h0000_0080,
  parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_1000,
  localparam int IDW  = $clog2(NSRC + 1),
  localparam int NW   = (NSRC + 31) / 32,
  localparam int CTXW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int WW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic [31:0]     addr,
  output acc_kind_e       kind,
  output logic [IDW-1:0]  src_id,
  output logic [CTXW-1:0] ctx,
  output logic [WW-1:0]   word
);
  localparam logic [31:0] PRIO_END = PRIO_BASE + 32'(NSRC * 4);
  localparam logic [31:0] PEND_END = PEND_BASE + 32'(NW * 4);
  localparam logic [31:0] EN_END   = EN_BASE + 32'(NCTX) * EN_STRIDE;
  localparam logic [31:0] CTX_END  = CTX_BASE + 32'(NCTX) * CTX_STRIDE;
  localparam int EN_SH  = $clog2(EN_STRIDE);
  localparam int CTX_SH = $clog2(CTX_STRIDE);

  logic [31:0] off;
  logic [31:0] inner;

  always_comb begin
    kind   = ACC_NONE;
    src_id = '0;
    ctx    = '0;
    word   = '0;
    off    = '0;
    inner  = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr >= PRIO_BASE && addr < PRIO_END) begin
        off    = addr - PRIO_BASE;
        kind   = ACC_PRIO;
        src_id = IDW'((off >> 2) + 32'd1);
      end else if (addr >= PEND_BASE && addr < PEND_END) begin
        off  = addr - PEND_BASE;
        kind = ACC_PEND;
        word = WW'(off >> 2);
      end else if (addr >= EN_BASE && addr < EN_END) begin
        off   = addr - EN_BASE;
        inner = (off & (EN_STRIDE - 32'd1)) >> 2;
        ctx   = CTXW'(off >> EN_SH);
        if (inner < 32'(NW)) begin
          kind = ACC_EN;
          word = WW'(inner);
        end
      end else if (addr >= CTX_BASE && addr < CTX_END) begin
        off   = addr - CTX_BASE;
        inner = off & (CTX_STRIDE - 32'd1);
        ctx   = CTXW'(off >> CTX_SH);
        if (inner == 32'd0)      kind = ACC_THR;
        else if (inner == 32'd4) kind = ACC_CLAIM;
      end
    end
  end
endmodule

// File: rtl/irqdec_regs.sv
module irqdec_regs
  import irqdec_pkg::*;
#(
  parameter int NSRC     = 40,
  parameter int NCTX     = 2,
  parameter int PRIO_W   = 3,
  parameter int MAX_PRIO = 7,
  localparam int IDW  = $clog2(NSRC + 1),
  localparam int NW   = (NSRC + 31) / 32,
  localparam int CTXW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int WW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  acc_kind_e              kind,
  input  logic [IDW-1:0]         src_id,
  input  logic [CTXW-1:0]        ctx,
  input  logic [WW-1:0]          word,
  input  logic [31:0]            wdata,
  output logic [NSRC*PRIO_W-1:0] prio_o,
  output logic [NCTX*NSRC-1:0]   en_o,
  output logic [NCTX*PRIO_W-1:0] thr_o
);
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [NSRC-1:0]   en_q   [NCTX];
  logic [PRIO_W-1:0] thr_q  [NCTX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio_q[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end
    end else if (we) begin
      case (kind)
        ACC_PRIO: prio_q[int'(src_id) - 1] <= wdata[PRIO_W-1:0];
        ACC_EN: begin
          for (int b = 0; b < 32; b++) begin
            if (32 * int'(word) + b >= 1 && 32 * int'(word) + b <= NSRC)
              en_q[int'(ctx)][32 * int'(word) + b - 1] <= wdata[b];
          end
        end
        ACC_THR: if (wdata <= 32'(MAX_PRIO)) thr_q[int'(ctx)] <= PRIO_W'(wdata);
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    assign prio_o[i*PRIO_W +: PRIO_W] = prio_q[i];
  end
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    assign en_o[c*NSRC +: NSRC]      = en_q[c];
    assign thr_o[c*PRIO_W +: PRIO_W] = thr_q[c];
    p_thr_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr_o[c*PRIO_W +: PRIO_W]) <= MAX_PRIO);
  end

  p_prio_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && kind == ACC_PRIO) |=> $stable(prio_o));
  p_en_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && kind == ACC_EN) |=> $stable(en_o));
endmodule

// File: rtl/intc_reg_decoder.sv
module intc_reg_decoder
  import irqdec_pkg::*;
#(
  parameter int          NSRC       = 40,
  parameter int          NCTX       = 2,
  parameter int          PRIO_W     = 3,
  parameter int          MAX_PRIO   = 7,
  parameter logic [31:0] PRIO_BASE  = 32'h0000_0000,
  parameter logic [31:0] PEND_BASE  = 32'h0000_1000,
  parameter logic [31:0] EN_BASE    = 32'h0000_2000,
  parameter logic [31:0] EN_STRIDE  = 32'h0000_0080,
  parameter logic [31:0] CTX_BASE   = 32'h0020_0000,
  parameter logic [31:0] CTX_STRIDE = 32'h0000_1000,
  localparam int IDW  = $clog2(NSRC + 1),
  localparam int NW   = (NSRC + 31) / 32,
  localparam int CTXW = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int WW   = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [31:0]            req_addr,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic                   rsp_err,
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NCTX*IDW-1:0]    claim_id_i,
  output logic [NSRC*PRIO_W-1:0] prio_o,
  output logic [NCTX*NSRC-1:0]   en_o,
  output logic [NCTX*PRIO_W-1:0] thr_o,
  output logic                   claim_o,
  output logic                   complete_o,
  output logic [CTXW-1:0]        evt_ctx_o,
  output logic [IDW-1:0]         complete_id_o
);
  acc_kind_e       kind;
  logic [IDW-1:0]  src_id;
  logic [CTXW-1:0] ctx;
  logic [WW-1:0]   word;

  // Gather the 32 bits of word w from a per-source vector (bit s-1 = source s).
  function automatic logic [31:0] word_of(input logic [NSRC-1:0] v, input logic [WW-1:0] w);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) begin
      if (32 * int'(w) + b >= 1 && 32 * int'(w) + b <= NSRC)
        r[b] = v[32 * int'(w) + b - 1];
    end
    return r;
  endfunction

  function automatic logic id_in_range(input logic [31:0] v);
    return v >= 32'd1 && v <= 32'(NSRC);
  endfunction

  irqdec_addr_map #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_BASE(PRIO_BASE), .PEND_BASE(PEND_BASE),
    .EN_BASE(EN_BASE), .EN_STRIDE(EN_STRIDE), .CTX_BASE(CTX_BASE), .CTX_STRIDE(CTX_STRIDE)
  ) i_map (
    .addr(req_addr), .kind(kind), .src_id(src_id), .ctx(ctx), .word(word)
  );

  // Named access events, shared by the datapath and the assertions.
  logic acc_rd, acc_wr, acc_bad, store_we, claim_ev, cmpl_ev;
  assign acc_rd   = req_valid && !req_write;
  assign acc_wr   = req_valid && req_write;
  assign acc_bad  = (kind == ACC_NONE) || (acc_wr && kind == ACC_PEND) ||
                    (acc_wr && kind == ACC_CLAIM && !id_in_range(req_wdata));
  assign store_we = acc_wr && !acc_bad;
  assign claim_ev = acc_rd && kind == ACC_CLAIM;
  assign cmpl_ev  = acc_wr && kind == ACC_CLAIM && id_in_range(req_wdata);

  irqdec_regs #(
    .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .MAX_PRIO(MAX_PRIO)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .we(store_we), .kind(kind), .src_id(src_id),
    .ctx(ctx), .word(word), .wdata(req_wdata),
    .prio_o(prio_o), .en_o(en_o), .thr_o(thr_o)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (kind)
      ACC_PRIO:  rd_mux = 32'(prio_o[(int'(src_id) - 1) * PRIO_W +: PRIO_W]);
      ACC_PEND:  rd_mux = word_of(pend_i, word);
      ACC_EN:    rd_mux = word_of(en_o[int'(ctx) * NSRC +: NSRC], word);
      ACC_THR:   rd_mux = 32'(thr_o[int'(ctx) * PRIO_W +: PRIO_W]);
      ACC_CLAIM: rd_mux = 32'(claim_id_i[int'(ctx) * IDW +: IDW]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_err       <= 1'b0;
      claim_o       <= 1'b0;
      complete_o    <= 1'b0;
      evt_ctx_o     <= '0;
      complete_id_o <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_rdata  <= (acc_rd && !acc_bad) ? rd_mux : 32'd0;
      rsp_err    <= req_valid && acc_bad;
      claim_o    <= claim_ev;
      complete_o <= cmpl_ev;
      if (claim_ev || cmpl_ev) evt_ctx_o <= ctx;
      if (cmpl_ev) complete_id_o <= IDW'(req_wdata);
    end
  end

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_misalign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'd0));
  p_claim_with_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_o |-> (rsp_valid && !rsp_err));
  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_o && complete_o));
  p_cmpl_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    complete_o |-> (int'(complete_id_o) >= 1 && int'(complete_id_o) <= NSRC && rsp_rdata == 32'd0));
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'd0 && !claim_o && !complete_o));
endmodule

// File: tb/test_intc_reg_decoder.sv
module test_intc_reg_decoder;
  localparam int NSRC = 40, NCTX = 2, PRIO_W = 3;
  localparam int IDW = $clog2(NSRC + 1);
  localparam int CTXW = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_err, claim_o, complete_o;
  logic [31:0] rsp_rdata;
  logic [NSRC-1:0] pend_i = '0;
  logic [NCTX*IDW-1:0] claim_id_i = '0;
  logic [NSRC*PRIO_W-1:0] prio_o;
  logic [NCTX*NSRC-1:0] en_o;
  logic [NCTX*PRIO_W-1:0] thr_o;
  logic [CTXW-1:0] evt_ctx_o;
  logic [IDW-1:0] complete_id_o;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  intc_reg_decoder i_intc_reg_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .pend_i(pend_i),
    .claim_id_i(claim_id_i), .prio_o(prio_o), .en_o(en_o), .thr_o(thr_o),
    .claim_o(claim_o), .complete_o(complete_o), .evt_ctx_o(evt_ctx_o),
    .complete_id_o(complete_id_o)
  );

  // Address helpers restate the default map.
  function automatic logic [31:0] a_prio(int src); return 32'((src - 1) * 4); endfunction
  function automatic logic [31:0] a_pend(int w); return 32'h1000 + 32'(w * 4); endfunction
  function automatic logic [31:0] a_en(int c, int w); return 32'h2000 + 32'(c * 'h80 + w * 4); endfunction
  function automatic logic [31:0] a_ctx(int c, int o); return 32'h20_0000 + 32'(c * 'h1000 + o); endfunction

  typedef struct {
    logic [31:0] rdata;
    bit err, clm, cpl;
    int ctx, id;
    string tag;
  } exp_t;
  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [31:0] erd, input bit eerr, input bit eclm, input bit ecpl,
                        input int ectx, input int eid, input string tag);
    exp_t e;
    e.rdata = erd; e.err = eerr; e.clm = eclm; e.cpl = ecpl; e.ctx = ectx; e.id = eid; e.tag = tag;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] a, input logic [31:0] erd, input bit eerr, input string tag);
    access(1'b0, a, 32'd0, erd, eerr, 1'b0, 1'b0, 0, 0, tag);
  endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d, input bit eerr, input string tag);
    access(1'b1, a, d, 32'd0, eerr, 1'b0, 1'b0, 0, 0, tag);
  endtask
  task automatic idle(input int n);
    req_valid = 1'b0; req_write = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops one expected item per response.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R1 response with no request", 128'(rsp_rdata), 128'd0);
        end else begin
          exp_t e;
          bit ok;
          e = sb.pop_front();
          ok = rsp_rdata == e.rdata && rsp_err == e.err && claim_o == e.clm &&
               complete_o == e.cpl &&
               (!(e.clm || e.cpl) || int'(evt_ctx_o) == e.ctx) &&
               (!e.cpl || int'(complete_id_o) == e.id);
          check(ok, e.tag,
                {rsp_rdata, 28'd0, rsp_err, claim_o, complete_o, 1'b0, 32'(evt_ctx_o), 32'(complete_id_o)},
                {e.rdata, 28'd0, e.err, e.clm, e.cpl, 1'b0, 32'(e.ctx), 32'(e.id)});
        end
      end else if (claim_o || complete_o) begin
        check(1'b0, "R7 strobe without response", {126'd0, claim_o, complete_o}, 128'd0);
      end
    end
  end

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state while reset is held
    check(!rsp_valid && !rsp_err && !claim_o && !complete_o, "R10 reset strobes",
          {rsp_valid, rsp_err, claim_o, complete_o}, 128'd0);
    check(prio_o == '0 && en_o == '0 && thr_o == '0, "R10 reset storage",
          128'(en_o), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: priority window, first and last source, width truncation
    wr(a_prio(1), 32'hFF, 1'b0, "R3 write source 1");
    wr(a_prio(NSRC), 32'd5, 1'b0, "R3 write last source");
    rd(a_prio(1), 32'd7, 1'b0, "R3 read source 1");
    rd(a_prio(NSRC), 32'd5, 1'b0, "R3 read last source");
    rd(a_prio(2), 32'd0, 1'b0, "R3 untouched source reads 0");
    rd(a_prio(NSRC + 1), 32'd0, 1'b1, "R9 just past priority window");
    idle(1);
    check(prio_o[2:0] == 3'd7 && prio_o[(NSRC-1)*PRIO_W +: PRIO_W] == 3'd5 &&
          prio_o[PRIO_W +: PRIO_W] == 3'd0, "R3 prio_o slices", 128'(prio_o), 128'd0);

    // R4: pending window
    pend_i = '0;
    pend_i[0] = 1'b1;        // source 1
    pend_i[30] = 1'b1;       // source 31
    pend_i[NSRC-1] = 1'b1;   // source 40
    rd(a_pend(0), 32'h8000_0002, 1'b0, "R4 pending word 0");
    rd(a_pend(1), 32'h0000_0100, 1'b0, "R4 pending word 1");
    wr(a_pend(0), 32'hFFFF_FFFF, 1'b1, "R4 pending write rejected");
    rd(a_pend(0), 32'h8000_0002, 1'b0, "R4 pending word 0 after write");
    idle(1);

    // R5: enable window for context 1
    wr(a_en(1, 0), 32'hFFFF_FFFF, 1'b0, "R5 enable ctx1 word0");
    wr(a_en(1, 1), 32'hFFFF_FFFF, 1'b0, "R5 enable ctx1 word1");
    wr(a_en(1, 2), 32'hFFFF_FFFF, 1'b1, "R5 enable word index too high");
    rd(a_en(1, 0), 32'hFFFF_FFFE, 1'b0, "R5 read ctx1 word0 source0 bit");
    rd(a_en(1, 1), 32'h0000_01FF, 1'b0, "R5 read ctx1 word1 upper bits");
    rd(a_en(1, 2), 32'd0, 1'b1, "R5 read invalid word");
    rd(a_en(0, 0), 32'd0, 1'b0, "R5 ctx0 untouched");
    idle(1);
    check(en_o == {{NSRC{1'b1}}, {NSRC{1'b0}}}, "R5 en_o layout", 128'(en_o),
          128'({{NSRC{1'b1}}, {NSRC{1'b0}}}));

    // R6: threshold
    wr(a_ctx(1, 0), 32'd5, 1'b0, "R6 threshold write ctx1");
    rd(a_ctx(1, 0), 32'd5, 1'b0, "R6 threshold read ctx1");
    wr(a_ctx(1, 0), 32'd9, 1'b0, "R6 oversize threshold no error");
    rd(a_ctx(1, 0), 32'd5, 1'b0, "R6 oversize threshold dropped");
    idle(1);
    check(thr_o == {3'd5, 3'd0}, "R6 thr_o layout", 128'(thr_o), 128'({3'd5, 3'd0}));

    // R7: claim reads
    claim_id_i = {6'd40, 6'd17};
    access(1'b0, a_ctx(0, 4), 32'd0, 32'd17, 1'b0, 1'b1, 1'b0, 0, 0, "R7 claim ctx0");
    access(1'b0, a_ctx(1, 4), 32'd0, 32'd40, 1'b0, 1'b1, 1'b0, 1, 0, "R7 claim ctx1");
    idle(1);

    // R8: complete writes
    access(1'b1, a_ctx(1, 4), 32'd12, 32'd0, 1'b0, 1'b0, 1'b1, 1, 12, "R8 complete id 12");
    access(1'b1, a_ctx(0, 4), 32'd40, 32'd0, 1'b0, 1'b0, 1'b1, 0, 40, "R8 complete last id");
    wr(a_ctx(1, 4), 32'd41, 1'b1, "R8 complete id out of range");
    wr(a_ctx(0, 4), 32'd0, 1'b1, "R8 complete id 0");
    idle(1);

    // R1: complete then claim with no gap, each strobe in its own response
    claim_id_i = {6'd3, 6'd9};
    access(1'b1, a_ctx(1, 4), 32'd7, 32'd0, 1'b0, 1'b0, 1'b1, 1, 7, "R1 back-to-back complete");
    access(1'b0, a_ctx(0, 4), 32'd0, 32'd9, 1'b0, 1'b1, 1'b0, 0, 0, "R1 back-to-back claim");
    idle(1);

    // R2: misaligned
    rd(32'h0000_0002, 32'd0, 1'b1, "R2 misaligned read");
    wr(32'h0000_0001, 32'd3, 1'b1, "R2 misaligned write");
    rd(a_prio(1), 32'd7, 1'b0, "R2 source 1 unchanged");

    // R9: unmapped and bad context offsets
    rd(a_ctx(0, 8), 32'd0, 1'b1, "R9 context offset 8");
    wr(a_ctx(1, 12), 32'd1, 1'b1, "R9 context offset 12 write");
    rd(32'h0000_3000, 32'd0, 1'b1, "R9 unmapped address");
    idle(3);

    check(sb.size() == 0, "R1 all responses seen", 128'(sb.size()), 128'd0);
    finish_run();
  end
endmodule